// File: doc/BRIEF.md
# Low-speed USB packet receiver

This block takes the D+ and D- wires of a low-speed USB link, oversampled by a free-running system clock, and recovers the bytes of each packet. While the bus is idle it waits for a falling edge on D-. It then watches the sync field until it sees two K bit times in a row, and from that point it decodes NRZI, drops stuffed bits and collects bits LSB-first into bytes. Each finished byte goes out on a one-cycle write port with an index that starts at zero, so the byte can be written straight into a receive buffer.

A packet ends on SE0, which is both wires low. SE0 is not taken as end of packet when it falls on the first bit of a byte, because a hub may add a stray bit just before the end. Two conditions produce a one-cycle error pulse: a byte that arrives when the buffer is already full, and a sync field that does not complete within a bounded number of bit times. The block does not check PID or CRC, does not filter addresses and does not transmit.

Top module: `usb_ls_rx`

## Requirements
- R1: During and right after the synchronous reset, wr_en_o, pkt_done_o, err_ovf_o and err_sync_o are 0, and pkt_len_o, wr_addr_o and wr_data_o are 0.
- R2: Line levels are J = (D+ 0, D- 1), K = (D+ 1, D- 0) and SE0 = (0, 0). Idle is J. A J-to-K edge starts the hunt, and the block locks after two K samples in a row. If the edge is followed by a single K and then J (a false start), the block keeps hunting, and a complete sync field that follows inside the window still locks.
- R3: A data bit is 1 when the sampled D- level equals the level of the previous bit, and 0 when it differs. Bytes are assembled LSB-first and appear on wr_data_o.
- R4: After six decoded 1 bits in a row, the next bit is discarded. The run counts from the final 1 of the sync field, is cleared by any 0 and continues across byte boundaries.
- R5: wr_en_o pulses for one cycle for each completed byte. wr_addr_o is 0 for the first byte after sync and increases by 1 for each following byte.
- R6: SE0 sampled at bit position 1 to 7 of a byte ends the packet. pkt_done_o then pulses for one cycle and pkt_len_o gives the number of bytes written, with the sync byte not counted. A partial byte is dropped.
- R7: SE0 sampled at bit position 0 of a byte does not end the packet. It is decoded as a bit whose D- level is 0, so a trailing stray bit or a lone SE0 at bit 0 leaves the stored bytes intact.
- R8: When a byte completes and BUF_DEPTH bytes are already stored, err_ovf_o pulses for one cycle. That byte is not written, no pkt_done_o follows for the packet, and the next packet is received normally.
- R9: If no two consecutive K samples are seen within SYNC_LIMIT bit samples after the J-to-K edge, err_sync_o pulses for one cycle, and no byte is written and no pkt_done_o is given for that attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLKS_PER_BIT cycles per bit |
| rst | input | 1 | Synchronous reset, active high |
| dp_i | input | 1 | D+ line, asynchronous to clk |
| dm_i | input | 1 | D- line, asynchronous to clk |
| wr_en_o | output | 1 | One-cycle strobe: a received byte is valid |
| wr_addr_o | output | $clog2(BUF_DEPTH) | Byte index within the packet |
| wr_data_o | output | 8 | Received byte |
| pkt_done_o | output | 1 | One-cycle end-of-packet pulse |
| pkt_len_o | output | $clog2(BUF_DEPTH+1) | Bytes received, valid with pkt_done_o |
| err_ovf_o | output | 1 | One-cycle buffer overflow pulse |
| err_sync_o | output | 1 | One-cycle pulse: sync field did not complete |

## Verification
The bench targets these corner cases:
- Bytes such as 0xFF and the pair 0xFC, 0x7E make a stuffed bit land inside a byte and on a byte boundary. A design that clears the ones-run at each byte, or that forgets the last sync bit, shifts a stuffed bit into the data or drops a real bit.
- A false start before the sync field, where one K is followed by J, would fail the sync at once in a design that does not keep hunting. A lone K followed by idle must give a sync error rather than hang in the hunt.
- A stray bit before end of packet, and a lone SE0 placed on bit 0 inside a packet, would cut the packet short in a design that honours SE0 at bit 0.
- A nine-byte packet into an eight-entry buffer must raise overflow and write nothing past index 7.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;
  localparam int BYTE_W    = 8;
  localparam int STUFF_RUN = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA
  } rx_state_t;

  // line pair packed as {dp, dm}
  localparam logic [1:0] LINE_J   = 2'b01;
  localparam logic [1:0] LINE_K   = 2'b10;
  localparam logic [1:0] LINE_SE0 = 2'b00;
endpackage

// File: rtl/usb_ls_rx_sync.sv
module usb_ls_rx_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= RST_VAL;
      else if (g == 0) stg[g] <= d;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/usb_ls_rx_phase.sv
module usb_ls_rx_phase
  import usb_ls_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 10,
  localparam int CW = $clog2(CLKS_PER_BIT),
  localparam int HALF = CLKS_PER_BIT / 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line,
  output logic       strobe,
  output logic [1:0] smp,
  output logic       jk_edge
);
  logic [1:0]    line_q;
  logic [CW-1:0] cnt;
  logic          changed;

  assign changed = (line != line_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= LINE_J;
      cnt     <= '0;
      strobe  <= 1'b0;
      smp     <= LINE_J;
      jk_edge <= 1'b0;
    end else begin
      line_q  <= line;
      jk_edge <= (line_q == LINE_J) && (line == LINE_K);
      // re-centre on every transition, otherwise free-run one bit period
      if (changed || cnt == CW'(CLKS_PER_BIT - 1)) cnt <= '0;
      else cnt <= cnt + CW'(1);
      strobe <= !changed && (cnt == CW'(HALF - 1));
      smp    <= line;
    end
  end
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 10,
  parameter int BUF_DEPTH = 8,
  parameter int SYNC_LIMIT = 16,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int LW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dp_i,
  input  logic          dm_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          pkt_done_o,
  output logic [LW-1:0] pkt_len_o,
  output logic          err_ovf_o,
  output logic          err_sync_o
);
  localparam int HW = $clog2(SYNC_LIMIT + 1);

  logic [1:0] line_s, smp;
  logic       strobe, jk_edge;

  usb_ls_rx_sync #(.W(2), .STAGES(2), .RST_VAL(LINE_J)) u_sync (
    .clk(clk), .rst(rst), .d({dp_i, dm_i}), .q(line_s)
  );

  usb_ls_rx_phase #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_phase (
    .clk(clk), .rst(rst), .line(line_s),
    .strobe(strobe), .smp(smp), .jk_edge(jk_edge)
  );

  rx_state_t         state;
  logic [HW-1:0]     hunt;
  logic              prev_k;
  logic              prev_dm;
  logic [2:0]        run;
  logic [2:0]        bitpos;
  logic [BYTE_W-1:0] shreg, sh_next;
  logic [LW-1:0]     count;
  logic              nrzi_bit, is_k, is_se0;

  always_comb begin
    is_k     = (smp == LINE_K);
    is_se0   = (smp == LINE_SE0);
    nrzi_bit = (smp[0] == prev_dm);
    sh_next  = {nrzi_bit, shreg[BYTE_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      hunt       <= '0;
      prev_k     <= 1'b0;
      prev_dm    <= 1'b1;
      run        <= '0;
      bitpos     <= '0;
      shreg      <= '0;
      count      <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      pkt_done_o <= 1'b0;
      pkt_len_o  <= '0;
      err_ovf_o  <= 1'b0;
      err_sync_o <= 1'b0;
    end else begin
      wr_en_o    <= 1'b0;
      pkt_done_o <= 1'b0;
      err_ovf_o  <= 1'b0;
      err_sync_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (jk_edge) begin
            state  <= ST_SYNC;
            hunt   <= '0;
            prev_k <= 1'b0;
          end
        end
        ST_SYNC: begin
          if (strobe) begin
            if (is_k && prev_k) begin
              state   <= ST_DATA;
              prev_dm <= 1'b0;
              run     <= 3'd1;      // final sync bit is a 1
              bitpos  <= '0;
              count   <= '0;
            end else begin
              prev_k <= is_k;
              if (hunt == HW'(SYNC_LIMIT - 1)) begin
                err_sync_o <= 1'b1;
                state      <= ST_IDLE;
              end else begin
                hunt <= hunt + HW'(1);
              end
            end
          end
        end
        ST_DATA: begin
          if (strobe) begin
            if (is_se0 && bitpos != 3'd0) begin
              pkt_done_o <= 1'b1;
              pkt_len_o  <= count;
              state      <= ST_IDLE;
            end else begin
              prev_dm <= smp[0];
              if (run == 3'(STUFF_RUN)) begin
                run <= '0;                // stuffed bit dropped
              end else begin
                run    <= nrzi_bit ? run + 3'd1 : 3'd0;
                shreg  <= sh_next;
                bitpos <= bitpos + 3'd1;
                if (bitpos == 3'd7) begin
                  if (count == LW'(BUF_DEPTH)) begin
                    err_ovf_o <= 1'b1;
                    state     <= ST_IDLE;
                  end else begin
                    wr_en_o   <= 1'b1;
                    wr_data_o <= sh_next;
                    wr_addr_o <= count[AW-1:0];
                    count     <= count + LW'(1);
                  end
                end
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk #(
  parameter int BUF_DEPTH = 8,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int LW = $clog2(BUF_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic          pkt_done_o,
  input logic [LW-1:0] pkt_len_o,
  input logic          err_ovf_o,
  input logic          err_sync_o
);
  logic [LW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) wcnt <= '0;
    else if (pkt_done_o || err_ovf_o || err_sync_o) wcnt <= '0;
    else if (wr_en_o) wcnt <= wcnt + LW'(1);
  end

  p_addr_seq_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_addr_o == wcnt[AW-1:0]) && (wcnt < LW'(BUF_DEPTH)));
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o);
  p_len_match_r6: assert property (@(posedge clk) disable iff (rst)
    pkt_done_o |-> pkt_len_o == wcnt);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    pkt_done_o |=> !pkt_done_o);
  p_one_event_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pkt_done_o, err_ovf_o, err_sync_o, wr_en_o}));
  p_ovf_full_r8: assert property (@(posedge clk) disable iff (rst)
    err_ovf_o |-> wcnt == LW'(BUF_DEPTH));
  p_sync_clean_r9: assert property (@(posedge clk) disable iff (rst)
    err_sync_o |-> wcnt == '0);
endmodule

bind usb_ls_rx usb_ls_rx_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
  .pkt_done_o(pkt_done_o), .pkt_len_o(pkt_len_o),
  .err_ovf_o(err_ovf_o), .err_sync_o(err_sync_o)
);

// File: tb/usb_ls_rx_test.sv
`timescale 1ns/1ps
module usb_ls_rx_test;
  localparam int CPB = 10;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  // {byte count, bytes packed with byte 0 in the low bits}
  localparam logic [39:0] VEC [4] = '{
    {8'd1, 32'h000000A5},
    {8'd2, 32'h0000FF00},
    {8'd3, 32'h007EFC3F},
    {8'd4, 32'hFFFF8001}
  };

  logic clk = 1'b0, rst = 1'b1, dp_i = 1'b0, dm_i = 1'b1;
  logic wr_en_o, pkt_done_o, err_ovf_o, err_sync_o;
  logic [AW-1:0] wr_addr_o;
  logic [7:0] wr_data_o;
  logic [LW-1:0] pkt_len_o;

  usb_ls_rx #(.CLKS_PER_BIT(CPB), .BUF_DEPTH(DEPTH), .SYNC_LIMIT(16)) uut (
    .clk(clk), .rst(rst), .dp_i(dp_i), .dm_i(dm_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .pkt_done_o(pkt_done_o), .pkt_len_o(pkt_len_o),
    .err_ovf_o(err_ovf_o), .err_sync_o(err_sync_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int wr_n = 0, done_n = 0, ovf_n = 0, serr_n = 0, last_len = 0;
  logic [7:0] cap_d [128];
  int cap_a [128];

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en_o && wr_n < 128) begin
        cap_d[wr_n] = wr_data_o;
        cap_a[wr_n] = int'(wr_addr_o);
        wr_n = wr_n + 1;
      end
      if (pkt_done_o) begin done_n = done_n + 1; last_len = int'(pkt_len_o); end
      if (err_ovf_o) ovf_n = ovf_n + 1;
      if (err_sync_o) serr_n = serr_n + 1;
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk = n_chk + 1; n_fail = n_fail + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      report();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic lvl;      // D- level, 1 = J
  int run;

  task automatic drive(input logic p, input logic m);
    dp_i = p; dm_i = m;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic tx_bit(input logic b, input logic se0_if_k);
    if (!b) lvl = ~lvl;
    if (se0_if_k && !lvl) drive(1'b0, 1'b0);
    else drive(~lvl, lvl);
    if (b) run = run + 1; else run = 0;
    if (run == 6) begin
      lvl = ~lvl; drive(~lvl, lvl); run = 0;
    end
  endtask

  task automatic tx_byte(input logic [7:0] v, input logic inj);
    for (int i = 0; i < 8; i++) tx_bit(v[i], inj && (i == 0));
  endtask

  task automatic tx_eop;
    drive(1'b0, 1'b0); drive(1'b0, 1'b0);
    lvl = 1'b1;
    repeat (4) drive(1'b0, 1'b1);
  endtask

  task automatic send_pkt(input int n, input logic [95:0] data, input int inj_idx,
                          input logic dribble);
    lvl = 1'b1; run = 0;
    tx_byte(8'h80, 1'b0);
    for (int k = 0; k < n; k++) tx_byte(data[8*k +: 8], k == inj_idx);
    if (dribble) tx_bit(1'b1, 1'b0);
    tx_eop();
  endtask

  task automatic expect_pkt(input string req, input int n, input logic [95:0] data,
                            input int w0, input int d0);
    check({req, " byte count"}, wr_n - w0, n);
    for (int k = 0; k < n && (w0 + k) < 128; k++) begin
      check({req, " data"}, int'(cap_d[w0 + k]), int'(data[8*k +: 8]));
      check({req, " addr R5"}, cap_a[w0 + k], k);
    end
    check({req, " done R6"}, done_n - d0, 1);
    check({req, " len R6"}, last_len, n);
  endtask

  initial begin
    int w0, d0, o0, s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 wr_en", int'(wr_en_o), 0);
    check("R1 flags", int'({pkt_done_o, err_ovf_o, err_sync_o}), 0);
    check("R1 len/addr/data", int'({pkt_len_o, wr_addr_o, wr_data_o}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 after release", int'({wr_en_o, pkt_done_o, err_ovf_o, err_sync_o}), 0);
    repeat (3) drive(1'b0, 1'b1);

    // table: R3 NRZI/LSB-first, R4 stuffing across bytes, R5, R6
    for (int v = 0; v < 4; v++) begin
      w0 = wr_n; d0 = done_n;
      send_pkt(int'(VEC[v][39:32]), {64'h0, VEC[v][31:0]}, -1, 1'b0);
      expect_pkt($sformatf("R3 R4 vector %0d", v), int'(VEC[v][39:32]),
                 {64'h0, VEC[v][31:0]}, w0, d0);
    end

    // R2 false start: one K then J before the real sync field
    w0 = wr_n; d0 = done_n; s0 = serr_n;
    drive(1'b1, 1'b0); drive(1'b0, 1'b1);
    send_pkt(2, 96'h5AC3, -1, 1'b0);
    expect_pkt("R2 false start", 2, 96'h5AC3, w0, d0);
    check("R2 no sync error", serr_n - s0, 0);

    // R7 stray bit before EOP: SE0 lands on bit 1
    w0 = wr_n; d0 = done_n;
    send_pkt(2, 96'h3C81, -1, 1'b1);
    expect_pkt("R6 R7 dribble", 2, 96'h3C81, w0, d0);

    // R7 lone SE0 on bit 0 of byte 1 (line would be K there)
    w0 = wr_n; d0 = done_n;
    send_pkt(3, 96'h550201, 1, 1'b0);
    expect_pkt("R7 se0 at bit0", 3, 96'h550201, w0, d0);

    // R8 overflow: nine bytes into eight entries
    w0 = wr_n; d0 = done_n; o0 = ovf_n;
    send_pkt(9, 96'h99_8877_6655_4433_2211, -1, 1'b0);
    check("R8 writes capped", wr_n - w0, DEPTH);
    check("R8 overflow pulse", ovf_n - o0, 1);
    check("R8 no done", done_n - d0, 0);
    if (wr_n - w0 == DEPTH) check("R8 last addr", cap_a[w0 + DEPTH - 1], DEPTH - 1);
    w0 = wr_n; d0 = done_n;
    send_pkt(1, 96'h7E, -1, 1'b0);
    expect_pkt("R8 recovery", 1, 96'h7E, w0, d0);

    // R9 sync error: lone K then idle
    w0 = wr_n; d0 = done_n; s0 = serr_n;
    drive(1'b1, 1'b0);
    repeat (22) drive(1'b0, 1'b1);
    check("R9 sync error pulse", serr_n - s0, 1);
    check("R9 no writes", wr_n - w0, 0);
    check("R9 no done", done_n - d0, 0);
    w0 = wr_n; d0 = done_n;
    send_pkt(1, 96'hC3, -1, 1'b0);
    expect_pkt("R9 recovery", 1, 96'hC3, w0, d0);

    report();
  end
endmodule